// File: doc/BRIEF.md
# Keyed Watchdog Reset Controller

A small register-mapped block that issues a whole-system reset pulse when a software-loaded watchdog count runs out. It has three 32-bit registers: reset control, reset status and watchdog timeout. Every write must carry the key byte 0x5A in bits 31:24. A write with any other key is dropped.

Software loads a tick count into the timeout register and puts the full-reset code into the configuration field of the control register. The count falls by one every 16 timer clocks. When it reaches zero with the full-reset code selected, the block drives a fixed-length reset pulse, then disarms itself and clears the configuration field.

The status register is cleared only by the power-on reset, so a boot partition code written before the watchdog fires is still there afterwards. The six partition bits are interleaved on the even bit positions. All six set (pattern 0x555, partition 63) is the halt request. The decoded partition number is also driven on a port.

Top module: `wdog_rst_ctrl`

## Requirements
- R1: A write takes effect only when wdata_i[31:24] equals 0x5A. A write with any other key byte leaves every register unchanged and starts no countdown. A write to an unmapped offset is also dropped.
- R2: Register offsets are 0x1C (control), 0x20 (status) and 0x24 (timeout). A read returns its data on rdata_o in the cycle after the request. Bits 23:0 carry the stored payload and bits 31:24 read as zero. An unmapped offset reads as zero.
- R3: A read of the timeout register returns the remaining tick count in bits 11:0. A keyed write loads the count and restarts the divide-by-16 prescaler. The count then falls by one every 16 clocks until it reaches zero.
- R4: If the count steps from 1 to 0 while control bits 5:4 hold 2'b10 (full reset), sys_rst_o goes high for exactly 4 cycles. The pulse starts at the clock edge 16*N cycles after the edge that loaded count N.
- R5: When the pulse starts, control bits 5:4 are cleared to 2'b00, the other control bits keep their values, and the timeout reads zero.
- R6: A timeout of zero, or a configuration code other than 2'b10 when the count expires, produces no reset pulse.
- R7: The timeout may be written before the full-reset code is set. The pulse still fires at the edge 16*N cycles after the timeout write.
- R8: The status register keeps its value through the watchdog pulse. A halt request (0x555) written before the pulse reads back as 0x555 afterwards.
- R9: part_o gives the 6-bit partition number taken from status bits 10, 8, 6, 4, 2 and 0, with bit 0 as the least significant bit. It follows a status write in the cycle after the write edge.
- R10: Power-on reset (rst_ni low) clears all three registers and part_o, and holds sys_rst_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset from block base |
| wdata_i | input | 32 | Write data: key in bits 31:24, payload below |
| rdata_o | output | 32 | Read data, registered |
| sys_rst_o | output | 1 | Whole-system reset pulse |
| part_o | output | 6 | Decoded boot partition number |

## Verification
A write lands on the rising edge where req_i is high. Read data and part_o can be seen at the next falling edge, and the bench samples every result at a falling edge so no result depends on edge ordering. The reset pulse is due exactly 16*N edges after the edge that loaded the timeout. The bench counts edges from that load, accounting for the extra edge taken by any write issued after it. It compares sys_rst_o with the expected window on every cycle and checks that the pulse is neither early, late, nor longer than 4 cycles. Timeout readback is sampled at known edge counts, so the expected count is N minus the number of completed 16-cycle periods.

// File: rtl/wdog_rst_pkg.sv
package wdog_rst_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned KEY_W = 8;
  localparam int unsigned PAY_W = REG_W - KEY_W;
  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;

  localparam logic [7:0] OFS_CTRL = 8'h1C;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_TMO  = 8'h24;

  localparam int unsigned CFG_LSB   = 4;
  localparam int unsigned PART_BITS = 6;

  typedef enum logic [1:0] {
    CFG_NONE = 2'b00,
    CFG_ALT1 = 2'b01,
    CFG_FULL = 2'b10,
    CFG_ALT3 = 2'b11
  } rst_cfg_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_rst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TMO_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              fire_i,
  input  logic [TMO_W-1:0]  count_i,
  output logic [PAY_W-1:0]  stat_o,
  output rst_cfg_e          cfg_o,
  output logic              tmo_wr_o,
  output logic [TMO_W-1:0]  tmo_val_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic [PART_BITS-1:0] part_o
);
  logic [PAY_W-1:0] ctrl_q, stat_q;
  logic key_ok, wr, rd, sel_ctrl, sel_stat, sel_tmo;

  assign key_ok   = wdata_i[REG_W-1 -: KEY_W] == WR_KEY;
  assign wr       = req_i && we_i && key_ok;
  assign rd       = req_i && !we_i;
  assign sel_ctrl = addr_i == ADDR_W'(OFS_CTRL);
  assign sel_stat = addr_i == ADDR_W'(OFS_STAT);
  assign sel_tmo  = addr_i == ADDR_W'(OFS_TMO);

  // host write wins over the post-fire config clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr && sel_ctrl) begin
      ctrl_q <= wdata_i[PAY_W-1:0];
    end else if (fire_i) begin
      ctrl_q[CFG_LSB +: 2] <= CFG_NONE;
    end
  end

  // only power-on reset clears status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (wr && sel_stat) begin
      stat_q <= wdata_i[PAY_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (rd) begin
      if (sel_ctrl)      rdata_o <= {{KEY_W{1'b0}}, ctrl_q};
      else if (sel_stat) rdata_o <= {{KEY_W{1'b0}}, stat_q};
      else if (sel_tmo)  rdata_o <= REG_W'(count_i);
      else               rdata_o <= '0;
    end
  end

  for (genvar g = 0; g < PART_BITS; g++) begin : g_part
    assign part_o[g] = stat_q[2*g];
  end

  assign stat_o    = stat_q;
  assign cfg_o     = rst_cfg_e'(ctrl_q[CFG_LSB +: 2]);
  assign tmo_wr_o  = wr && sel_tmo;
  assign tmo_val_o = wdata_i[TMO_W-1:0];
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TMO_W     = 12,
  parameter int unsigned PRESC_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMO_W-1:0] load_val_i,
  input  logic             cfg_full_i,
  output logic [TMO_W-1:0] count_o,
  output logic             fire_o
);
  localparam int unsigned PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_MAX = PRESC_W'(PRESC_DIV - 1);

  logic [TMO_W-1:0]   count_q;
  logic [PRESC_W-1:0] presc_q;
  logic running, tick;

  assign running = count_q != '0;
  assign tick    = running && (presc_q == PRESC_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      presc_q <= '0;
    end else if (load_i) begin
      count_q <= load_val_i;
      presc_q <= '0;
    end else if (tick) begin
      count_q <= count_q - 1'b1;
      presc_q <= '0;
    end else if (running) begin
      presc_q <= presc_q + 1'b1;
    end
  end

  assign fire_o  = !load_i && tick && (count_q == TMO_W'(1)) && cfg_full_i;
  assign count_o = count_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);
  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (fire_i)        cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign rst_o = cnt_q != '0;
endmodule

// File: rtl/wdog_rst_ctrl.sv
module wdog_rst_ctrl
  import wdog_rst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TMO_W     = 12,
  parameter int unsigned PRESC_DIV = 16,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_o,
  output logic [5:0]        part_o
);
  logic [PAY_W-1:0] stat_w;
  rst_cfg_e         cfg_w;
  logic             tmo_wr_w, fire_w;
  logic [TMO_W-1:0] tmo_val_w, count_w;

  wdog_regs #(.ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .fire_i    (fire_w),
    .count_i   (count_w),
    .stat_o    (stat_w),
    .cfg_o     (cfg_w),
    .tmo_wr_o  (tmo_wr_w),
    .tmo_val_o (tmo_val_w),
    .rdata_o   (rdata_o),
    .part_o    (part_o)
  );

  wdog_timer #(.TMO_W(TMO_W), .PRESC_DIV(PRESC_DIV)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmo_wr_w),
    .load_val_i (tmo_val_w),
    .cfg_full_i (cfg_w == CFG_FULL),
    .count_o    (count_w),
    .fire_o     (fire_w)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire_w),
    .rst_o  (sys_rst_o)
  );
endmodule

// File: rtl/wdog_rst_ctrl_chk.sv
module wdog_rst_ctrl_chk
  import wdog_rst_pkg::*;
#(
  parameter int unsigned TMO_W     = 12,
  parameter int unsigned PULSE_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             sys_rst_o,
  input logic [PAY_W-1:0] stat_w,
  input rst_cfg_e         cfg_w,
  input logic             tmo_wr_w,
  input logic [TMO_W-1:0] count_w
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  // R1
  bad_key_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && wdata_i[31:24] != WR_KEY) |=> $stable(stat_w));

  // R2
  key_byte_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:24] == 8'h00);

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_w != $past(count_w) && !$past(tmo_wr_w)) |-> count_w == $past(count_w) - 1'b1);

  // R4
  pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> hi_cnt < HW'(PULSE_LEN));

  // R4
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> hi_cnt == HW'(PULSE_LEN));

  // R6
  fire_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(cfg_w) == CFG_FULL && $past(count_w) == TMO_W'(1)));
endmodule

bind wdog_rst_ctrl wdog_rst_ctrl_chk #(.TMO_W(TMO_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .sys_rst_o (sys_rst_o),
  .stat_w    (stat_w),
  .cfg_w     (cfg_w),
  .tmo_wr_w  (tmo_wr_w),
  .count_w   (count_w)
);

// File: tb/wdog_rst_ctrl_tb.sv
module wdog_rst_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sys_rst_o;
  logic [5:0]  part_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] m_ctrl, m_stat;

  always #5ns clk_i = ~clk_i;

  wdog_rst_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sys_rst_o(sys_rst_o), .part_o(part_o)
  );

  function automatic logic [5:0] exp_part(logic [23:0] s);
    logic [5:0] p;
    for (int i = 0; i < 6; i++) p[i] = s[2*i];
    return p;
  endfunction

  function automatic logic exp_pulse(int k, int n);
    return (n > 0) && (k >= 16*n) && (k < 16*n + 4);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns at the falling edge after the write edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  // k0 = edges already elapsed since the timeout load edge
  task automatic watch(string r, int k0, int n, int last);
    int bad = 0;
    logic seen_act = 1'b0;
    for (int k = k0; k <= last; k++) begin
      @(negedge clk_i);
      if (sys_rst_o !== exp_pulse(k, n)) begin
        if (bad == 0) seen_act = sys_rst_o;
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s pulse window mismatches=%0d first act=%b", r, bad, seen_act);
    end
  endtask

  initial begin
    #2_000_000ns;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk_i);
    // R10 power-on state
    chk("R10 sys_rst", {31'd0, sys_rst_o}, 32'd0);
    chk("R10 part", {26'd0, part_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(8'h1C, d); chk("R10 ctrl", d, 32'd0);
    rd(8'h20, d); chk("R10 stat", d, 32'd0);
    rd(8'h24, d); chk("R10 tmo", d, 32'd0);
    m_ctrl = '0; m_stat = '0;

    // R1 R2 random keyed/unkeyed writes with readback
    for (int i = 0; i < 80; i++) begin
      logic [7:0]  a, key;
      logic [31:0] v;
      int sel = $urandom_range(0, 2);
      a   = (sel == 0) ? 8'h1C : (sel == 1) ? 8'h20 : 8'h28;
      key = $urandom_range(0, 1) ? 8'h5A : 8'($urandom);
      v   = {key, 24'($urandom)};
      wr(a, v);
      if (key == 8'h5A && a == 8'h1C) m_ctrl = v[23:0];
      if (key == 8'h5A && a == 8'h20) m_stat = v[23:0];
      rd(a, d);
      if (a == 8'h1C)      chk("R1 R2 ctrl", d, {8'h0, m_ctrl});
      else if (a == 8'h20) chk("R1 R2 stat", d, {8'h0, m_stat});
      else                 chk("R2 unmapped", d, 32'd0);
      chk("R9 part", {26'd0, part_o}, {26'd0, exp_part(m_stat)});
    end

    // R3 countdown readback, cfg none so no pulse (R6)
    wr(8'h1C, 32'h5A00_0000);
    wr(8'h24, 32'h5A00_0005);
    rd(8'h24, d); chk("R3 tmo load", d, 32'd5);
    repeat (19) @(negedge clk_i);
    rd(8'h24, d); chk("R3 tmo after 20", d, 32'd4);
    watch("R6 cfg none", 21, 0, 120);
    rd(8'h24, d); chk("R3 tmo expired", d, 32'd0);

    // R6 zero timeout with full cfg
    wr(8'h1C, 32'h5A00_0123);
    wr(8'h24, 32'h5A00_0000);
    watch("R6 zero tmo", 1, 0, 60);

    // R1 unkeyed timeout write does not start countdown
    wr(8'h24, 32'hA500_0003);
    watch("R1 bad key tmo", 1, 0, 80);
    rd(8'h24, d); chk("R1 tmo unchanged", d, 32'd0);

    // R8 halt code, then R4 R5 full reset
    wr(8'h20, 32'h5A00_0555);
    chk("R9 halt part", {26'd0, part_o}, 32'd63);
    wr(8'h24, 32'h5A00_0002);
    watch("R4 pulse N=2", 1, 2, 40);
    rd(8'h1C, d); chk("R5 cfg cleared", d, 32'h0000_0103);
    rd(8'h24, d); chk("R5 tmo zero", d, 32'd0);
    rd(8'h20, d); chk("R8 stat kept", d, 32'h0000_0555);
    chk("R8 part kept", {26'd0, part_o}, 32'd63);

    // R9 sparse partition
    wr(8'h20, 32'h5A00_0044);
    chk("R9 part 10", {26'd0, part_o}, 32'd10);

    // R7 timeout first, then config
    wr(8'h24, 32'h5A00_0003);
    wr(8'h1C, 32'h5A00_0020);
    watch("R7 late cfg", 2, 3, 60);
    rd(8'h1C, d); chk("R5 cfg cleared 2", d, 32'd0);

    // R6 other code
    wr(8'h1C, 32'h5A00_0010);
    wr(8'h24, 32'h5A00_0002);
    watch("R6 cfg 01", 1, 0, 50);
    rd(8'h1C, d); chk("R6 cfg kept", d, 32'h0000_0010);

    // R10 power-on reset clears status
    wr(8'h20, 32'h5A00_0555);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 part clr", {26'd0, part_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(8'h20, d); chk("R10 stat clr", d, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule